// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a local countdown timer clocked from the local clock through a programmable power-of-two divider. Software loads a 32-bit start value; the block copies it into a running count and lowers that count by a fixed step on every divided tick. When the count runs out, the block emits a one-cycle interrupt request carrying an 8-bit vector, unless the vector entry is masked. Each run either stops at zero (one-shot) or reloads itself (periodic).

A single write port with a 2-bit select reaches four registers: the start value, the divider setting, the vector entry and a control word with a software-enable bit. The running count is always visible on an output port. Until software sets the enable bit, every write to the vector entry is stored with its mask bit set.

Top module: `divided_countdown_timer`

## Requirements
- R1: The divide ratio comes from divider bits {3,1,0} only: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. Bit 2 and bits 31:4 have no effect.
- R2: Writing the start value (select 0) loads the count with it and restarts the divider. The first decrement lands exactly one ratio of clocks after the write edge.
- R3: A start value of zero sets the count to 0 and stops the timer. No request follows until a nonzero start value is written.
- R4: In one-shot mode (entry bit 17 = 0), expiry leaves the count at 0 and idle. No further request comes until the start value is written again.
- R5: In periodic mode (entry bit 17 = 1), expiry reloads the count with start − (DEC_STEP − count), or with 0 when that overshoot reaches or exceeds the start value. Counting then continues.
- R6: Expiry drives `irq` high for one cycle with `irq_vector` equal to entry bits 7:0, but only when the mask (entry bit 16) is clear. A masked entry gives no request.
- R7: Reset leaves the entry masked and the software enable (control bit 8) clear. While the enable is clear, an entry write stores mask = 1 whatever bit 16 holds.
- R8: Each divided tick lowers a running count by DEC_STEP. Expiry happens on the tick where the count is at most DEC_STEP.
- R9: Select codes are 0 start value, 1 divider, 2 vector entry, 3 control. A divider write restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
On every cycle, the assertions check the following:
- a running count drops by exactly the step between ticks;
- a one-shot expiry leaves the count at zero and idle;
- an idle count holds still;
- the divider counter stays below the selected ratio;
- a forced mask is stored while the enable is off;
- a masked expiry stays silent, while an unmasked one yields a request with the entry's vector.

The bench's scenarios cover the rest:
- the exact divide ratio for all eight codes, with the don't-care bits set;
- the overshoot arithmetic of a periodic reload, including the clamp to zero;
- the silence after a zero start value and after a one-shot expiry;
- the reset-masked entry.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  localparam int ENTRY_MASK_BIT = 16;
  localparam int ENTRY_MODE_BIT = 17;
  localparam int CTRL_EN_BIT    = 8;
  localparam int VEC_W          = 8;
  localparam int SHIFT_W        = 3;

  typedef struct packed {
    logic             masked;
    logic             periodic;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // log2 of the divide ratio, from bits {3,1,0}; 111 wraps to 0 (ratio 1)
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    return {cfg[3], cfg[1], cfg[0]} + 3'd1;
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int MAX_SHIFT = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic [dct_pkg::SHIFT_W-1:0] shift,
  output logic                        tick
);
  localparam int PW = MAX_SHIFT;

  logic [PW-1:0] presc;
  logic [PW-1:0] limit;

  assign limit = PW'((1 << shift) - 1);
  assign tick  = (presc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         presc <= '0;
    else if (clr||tick) presc <= '0;
    else                presc <= presc + 1'b1;
  end

  // R1
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc <= limit);
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W    = 32,
  parameter int DEC_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(DEC_STEP);

  logic [CNT_W-1:0] start_q;

  // periodic reload value after an overshoot of (STEP - cur)
  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] start,
                                                  input logic [CNT_W-1:0] cur);
    logic [CNT_W-1:0] over;
    over = STEP - cur;
    return (start > over) ? (start - over) : '0;
  endfunction

  assign expire = !load && running && tick && (count <= STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count   <= '0;
      running <= 1'b0;
    end else if (load) begin
      start_q <= load_val;
      count   <= load_val;
      running <= (load_val != '0);
    end else if (running && tick) begin
      if (count <= STEP) begin
        if (periodic) count <= reload_val(start_q, count);
        else begin
          count   <= '0;
          running <= 1'b0;
        end
      end else begin
        count <= count - STEP;
      end
    end
  end

  // R8
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !load && !expire) |=> (count == $past(count) - STEP));
  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (count == '0 && !running));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(count));
endmodule

// File: rtl/dct_regs.sv
module dct_regs (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [31:0]                 wr_data,
  output dct_pkg::entry_t             entry,
  output logic [dct_pkg::SHIFT_W-1:0] shift,
  output logic                        load,
  output logic                        div_wr
);
  import dct_pkg::*;

  logic sw_en;
  logic entry_wr, ctrl_wr;

  assign load     = wr_en && (wr_sel == SEL_START);
  assign div_wr   = wr_en && (wr_sel == SEL_DIV);
  assign entry_wr = wr_en && (wr_sel == SEL_ENTRY);
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry <= '{masked: 1'b1, periodic: 1'b0, vector: '0};
      shift <= div_shift(4'd0);
      sw_en <= 1'b0;
    end else begin
      if (entry_wr) begin
        entry.masked   <= wr_data[ENTRY_MASK_BIT] | ~sw_en;
        entry.periodic <= wr_data[ENTRY_MODE_BIT];
        entry.vector   <= wr_data[VEC_W-1:0];
      end
      if (div_wr)  shift <= div_shift(wr_data[3:0]);
      if (ctrl_wr) sw_en <= wr_data[CTRL_EN_BIT];
    end
  end

  // R7
  forced_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_wr && !sw_en) |=> entry.masked);
endmodule

// File: rtl/divided_countdown_timer.sv
module divided_countdown_timer #(
  parameter int CNT_W     = 32,
  parameter int DEC_STEP  = 1,
  parameter int MAX_SHIFT = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [31:0]               wr_data,
  output logic [CNT_W-1:0]          cur_count,
  output logic                      irq,
  output logic [dct_pkg::VEC_W-1:0] irq_vector
);
  import dct_pkg::*;

  entry_t               entry;
  logic [SHIFT_W-1:0]   shift;
  logic                 load, div_wr, tick, running, expire;

  dct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .entry(entry), .shift(shift),
    .load(load), .div_wr(div_wr)
  );

  dct_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(load || div_wr),
    .shift(shift), .tick(tick)
  );

  dct_counter #(.CNT_W(CNT_W), .DEC_STEP(DEC_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(CNT_W'(wr_data)), .periodic(entry.periodic),
    .count(cur_count), .running(running), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq <= expire && !entry.masked;
      if (expire) irq_vector <= entry.vector;
    end
  end

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry.masked) |=> !irq);
  // R6
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !entry.masked) |=> (irq && irq_vector == $past(entry.vector)));
endmodule

// File: tb/divided_countdown_timer_tb.sv
`timescale 1ns/1ps
module divided_countdown_timer_tb;
  localparam int STEP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        irq;
  logic [7:0]  irq_vector;

  int errors = 0;
  int checks = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  divided_countdown_timer #(.DEC_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cur_count(cur_count), .irq(irq), .irq_vector(irq_vector)
  );

  // behavioural reference model
  longint m_cnt, m_start, m_presc;
  int     m_shift;
  bit     m_run, m_mask, m_per, m_en, m_irq;
  int     m_vec, m_ivec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_start = 0; m_presc = 0; m_shift = 1;
      m_run = 0; m_mask = 1; m_per = 0; m_en = 0; m_irq = 0;
      m_vec = 0; m_ivec = 0;
    end else begin
      bit tk, ld, ex;
      longint ov;
      tk = (m_presc == (longint'(1) << m_shift) - 1);
      ld = wr_en && wr_sel == 2'd0;
      ex = !ld && m_run && tk && (m_cnt <= STEP);
      m_irq = ex && !m_mask;
      if (ex) m_ivec = m_vec;
      if (ld) begin
        m_start = wr_data; m_cnt = wr_data; m_run = (wr_data != 0);
      end else if (m_run && tk) begin
        if (m_cnt <= STEP) begin
          if (m_per) begin
            ov = STEP - m_cnt;
            m_cnt = (m_start > ov) ? m_start - ov : 0;
          end else begin
            m_cnt = 0; m_run = 0;
          end
        end else m_cnt = m_cnt - STEP;
      end
      if (ld || (wr_en && wr_sel == 2'd1) || tk) m_presc = 0;
      else m_presc = m_presc + 1;
      if (wr_en && wr_sel == 2'd1)
        m_shift = ({wr_data[3], wr_data[1], wr_data[0]} + 1) % 8;
      if (wr_en && wr_sel == 2'd2) begin
        m_mask = wr_data[16] || !m_en;
        m_per  = wr_data[17];
        m_vec  = wr_data[7:0];
      end
      if (wr_en && wr_sel == 2'd3) m_en = wr_data[8];
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 count, R6 request)
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(cur_count == m_cnt, "R8 per-cycle count", cur_count, m_cnt);
      chk(irq == m_irq, "R6 per-cycle irq", irq, m_irq);
      if (m_irq) chk(irq_vector == m_ivec, "R6 per-cycle vector", irq_vector, m_ivec);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);
    chk(cur_count == 0, "R7 reset count", cur_count, 0);
    chk(irq == 0, "R7 reset irq", irq, 0);

    // R7: entry starts masked; enable only, no entry write
    wr(2'd3, 32'h100);
    wr(2'd0, 32'd3);
    quiet(20, "R7 reset-masked entry stays silent");

    // R5/R6 periodic, ratio 1, start 10, step 3
    wr(2'd1, 32'hB);
    wr(2'd2, 32'h0002_0041);
    wr(2'd0, 32'd10);
    chk(cur_count == 10, "R2 load", cur_count, 10);
    idle(3);
    chk(cur_count == 1 && irq == 0, "R8 three steps", cur_count, 1);
    idle(1);
    chk(irq == 1, "R6 irq on expiry", irq, 1);
    chk(irq_vector == 8'h41, "R6 vector", irq_vector, 8'h41);
    chk(cur_count == 8, "R5 overshoot reload", cur_count, 8);
    idle(1);
    chk(irq == 0, "R6 one-cycle pulse", irq, 0);

    // R5 clamp: start 2 below the overshoot
    wr(2'd0, 32'd2);
    idle(1);
    chk(cur_count == 1 && irq == 1, "R5 reload 2-1", cur_count, 1);
    idle(1);
    chk(cur_count == 0, "R5 clamp to zero", cur_count, 0);
    chk(irq == 1, "R5 periodic keeps firing", irq, 1);
    idle(1);
    chk(irq == 1 && cur_count == 0, "R5 zero reload refires", cur_count, 0);

    // R4 one-shot, ratio 4 (code 001), start 7
    wr(2'd2, 32'h0000_0022);
    wr(2'd1, 32'h1);
    wr(2'd0, 32'd7);
    idle(11);
    chk(irq == 0 && cur_count == 1, "R4 before expiry", cur_count, 1);
    idle(1);
    chk(irq == 1 && irq_vector == 8'h22, "R4 one-shot request", irq_vector, 8'h22);
    chk(cur_count == 0, "R4 stops at zero", cur_count, 0);
    quiet(40, "R4 no second request");
    chk(cur_count == 0, "R4 stays idle", cur_count, 0);

    // R6 masked entry
    wr(2'd1, 32'hB);
    wr(2'd2, 32'h0003_0033);
    wr(2'd0, 32'd4);
    idle(1);
    chk(cur_count == 1, "R6 masked still counts", cur_count, 1);
    quiet(20, "R6 masked gives no request");

    // R7 software enable clear forces the mask
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h0002_0055);
    wr(2'd0, 32'd4);
    quiet(20, "R7 forced mask while disabled");
    wr(2'd3, 32'h100);
    wr(2'd2, 32'h0002_0055);
    wr(2'd0, 32'd4);
    idle(2);
    chk(irq == 1 && irq_vector == 8'h55, "R7 enabled entry fires", irq_vector, 8'h55);

    // R3 zero start disables
    wr(2'd0, 32'd0);
    chk(cur_count == 0, "R3 zero start clears count", cur_count, 0);
    quiet(30, "R3 zero start never fires");

    // R1/R9 every divide code, don't-care bits set
    for (int code = 0; code < 8; code++) begin
      int ratio;
      logic [31:0] d;
      ratio = 1 << ((code + 1) % 8);
      d = 32'hFFFF_FFF4 | {28'd0, code[2], 1'b0, code[1], code[0]};
      wr(2'd1, d);
      wr(2'd0, 32'd1000);
      if (ratio > 1) begin
        idle(ratio - 1);
        chk(cur_count == 1000, "R1 no early decrement", cur_count, 1000);
        idle(1);
      end else idle(1);
      chk(cur_count == 1000 - STEP, "R1 decrement at ratio", cur_count, 1000 - STEP);
    end

    // R9 divider write restarts the divider mid-count (ratio 8, code 010)
    wr(2'd1, 32'h2);
    wr(2'd0, 32'd500);
    idle(5);
    wr(2'd1, 32'h2);
    idle(7);
    chk(cur_count == 500, "R9 divider restarted", cur_count, 500);
    idle(1);
    chk(cur_count == 500 - STEP, "R9 decrement after restart", cur_count, 500 - STEP);

    live = 0;
    summary();
    $finish;
  end
endmodule